// File: doc/BRIEF.md
# Serial Device Address CRC Checker

This block receives a 64-bit device address one bit per accepted transfer, least significant bit first. The first byte received is a family code. The next 48 bits are a serial number. The last byte is a CRC-8 check value. While the bits arrive, a bit-serial reflected CRC-8 runs over the first 56 bits. When the 64th bit lands, that CRC is compared with the final byte, and the family code is compared with a fixed expected value. The block reports the outcome on two flags and a one-cycle `done` pulse. It also presents the captured fields as outputs.

The bit input is a valid/ready stream. `bit_ready` goes high the cycle after a `start` pulse and stays high until the 64th bit has been accepted. A bit is accepted on a rising clock edge where `bit_valid` and `bit_ready` are both high and `start` is low. The sender may hold `bit_valid` low for any number of cycles. Once the frame is complete, `bit_ready` stays low, which back-pressures the sender until the next `start`.

A failed CRC or an unexpected family code only leaves the matching flag low. Framing, `done` and field capture proceed regardless, and the host decides what to do with the result.

Top module: `rom_addr_crc_check`

## Requirements
- R1: After reset, `bit_ready`, `done`, `crc_ok` and `family_ok` are all low.
- R2: In the cycle after a `start` pulse, `bit_ready` is high and `done`, `crc_ok` and `family_ok` are low.
- R3: Only cycles with `bit_valid` and `bit_ready` both high consume an address bit. Data presented while `bit_valid` is low has no effect on any output.
- R4: `bit_ready` falls in the cycle after the 64th accepted bit. Bits offered after that, until the next `start`, change no output.
- R5: `done` is high for exactly one cycle, in the cycle after the 64th bit is accepted.
- R6: Bit k of the address is the k-th accepted bit, counting from 0. The CRC register starts at 00h. For each of bits 0..55, the register is shifted right, and it is then XORed with 8Ch whenever (input bit XOR old register bit 0) is 1. `crc_ok` is set if and only if the result equals bits 63..56, with bit 56 as the LSB.
- R7: `family_ok` is set if and only if bits 7..0 equal 3Dh, with bit 0 as the LSB.
- R8: At `done` and until the next `start`: `family_code` shows bits 7..0, `serial_num` shows bits 55..8, and `crc_byte` shows bits 63..56. The flags are held over the same interval.
- R9: A CRC or family mismatch does not suppress `done`, the field outputs or the fall of `bit_ready`.
- R10: A `start` pulse in the middle of a frame discards the partial frame. Counting restarts from bit 0.
- R11: When `done` is high, `crc_ok` equals the condition that the same CRC run over all 64 bits leaves 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new frame: clears the count, the CRC and the flags |
| bit_valid | input | 1 | Address bit on `bit_data` is offered |
| bit_data | input | 1 | Address bit, LSB first |
| bit_ready | output | 1 | Block will accept a bit this cycle |
| done | output | 1 | One-cycle pulse after the 64th bit |
| crc_ok | output | 1 | Received CRC byte matches the computed CRC |
| family_ok | output | 1 | Family code equals 3Dh |
| family_code | output | 8 | Captured family byte |
| serial_num | output | 48 | Captured serial number |
| crc_byte | output | 8 | Captured CRC byte |

## Verification
The bench builds the block with its default field widths (8/48/8), polynomial 8Ch and expected code 3Dh. With these values the whole family-byte space is small enough to sweep. All 256 family codes are sent with a correctly computed CRC, so `family_ok` is seen both high and low. Every one of the 64 single-bit corruptions of a valid address is also sent, which reaches `crc_ok` low at each bit position, including errors in the CRC byte itself. Bubbles on `bit_valid`, with inverted data during those bubbles, an aborted partial frame, and bits offered after completion exercise the acceptance and hold rules.

// File: rtl/rac_pkg.sv
package rac_pkg;
  typedef enum logic {
    RAC_IDLE = 1'b0,
    RAC_RECV = 1'b1
  } rac_state_t;
endpackage

// File: rtl/rac_crc_engine.sv
module rac_crc_engine #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     POLY = 8'h8C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] shifted;

  assign fb      = din ^ crc[0];
  assign shifted = crc >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n)      crc <= '0;
    else if (clear)  crc <= '0;
    else if (step)   crc <= fb ? (shifted ^ POLY) : shifted;
  end

  // register moves only on an accepted bit
  p_crc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(crc));
  p_crc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc == '0));
endmodule

// File: rtl/rac_frame_ctrl.sv
module rac_frame_ctrl #(
  parameter int ADDR_BITS    = 64,
  parameter int PAYLOAD_BITS = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bit_valid,
  output logic bit_ready,
  output logic accept,
  output logic in_payload,
  output logic last,
  output logic done
);
  import rac_pkg::*;

  localparam int CNT_W = $clog2(ADDR_BITS + 1);

  rac_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign bit_ready  = (state == RAC_RECV);
  assign accept     = bit_valid && bit_ready && !start;
  assign in_payload = accept && (cnt < CNT_W'(PAYLOAD_BITS));
  assign last       = accept && (cnt == CNT_W'(ADDR_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RAC_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (start) begin
      state <= RAC_RECV;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (accept) cnt <= cnt + 1'b1;
      if (last)   state <= RAC_IDLE;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(ADDR_BITS));
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !bit_ready);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0) && bit_ready);
endmodule

// File: rtl/rac_field_capture.sv
module rac_field_capture #(
  parameter int ADDR_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 accept,
  input  logic                 din,
  output logic [ADDR_BITS-1:0] shreg,
  output logic [ADDR_BITS-1:0] shreg_next
);
  // bits enter at the top and walk down, so the first bit ends at index 0
  assign shreg_next = {din, shreg[ADDR_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n)      shreg <= '0;
    else if (clear)  shreg <= '0;
    else if (accept) shreg <= shreg_next;
  end

  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clear) |=> $stable(shreg));
endmodule

// File: rtl/rom_addr_crc_check.sv
module rom_addr_crc_check #(
  parameter int                FAMILY_W    = 8,
  parameter int                SERIAL_W    = 48,
  parameter int                CRC_W       = 8,
  parameter logic [CRC_W-1:0]  POLY        = 8'h8C,
  parameter logic [FAMILY_W-1:0] FAMILY_CODE = 8'h3D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bit_valid,
  input  logic                bit_data,
  output logic                bit_ready,
  output logic                done,
  output logic                crc_ok,
  output logic                family_ok,
  output logic [FAMILY_W-1:0] family_code,
  output logic [SERIAL_W-1:0] serial_num,
  output logic [CRC_W-1:0]    crc_byte
);
  localparam int PAYLOAD_BITS = FAMILY_W + SERIAL_W;
  localparam int ADDR_BITS    = PAYLOAD_BITS + CRC_W;

  logic                 accept, in_payload, last;
  logic [CRC_W-1:0]     crc_payload, crc_residue;
  logic [ADDR_BITS-1:0] shreg, shreg_next;

  rac_frame_ctrl #(.ADDR_BITS(ADDR_BITS), .PAYLOAD_BITS(PAYLOAD_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .accept(accept), .in_payload(in_payload),
    .last(last), .done(done)
  );

  rac_field_capture #(.ADDR_BITS(ADDR_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(start), .accept(accept),
    .din(bit_data), .shreg(shreg), .shreg_next(shreg_next)
  );

  // CRC over family code and serial number only
  rac_crc_engine #(.W(CRC_W), .POLY(POLY)) u_crc_payload (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(in_payload),
    .din(bit_data), .crc(crc_payload)
  );

  // same CRC over the whole address; a valid address leaves zero
  rac_crc_engine #(.W(CRC_W), .POLY(POLY)) u_crc_residue (
    .clk(clk), .rst_n(rst_n), .clear(start), .step(accept),
    .din(bit_data), .crc(crc_residue)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      crc_ok    <= 1'b0;
      family_ok <= 1'b0;
    end else if (last) begin
      crc_ok    <= (crc_payload == shreg_next[ADDR_BITS-1 -: CRC_W]);
      family_ok <= (shreg_next[FAMILY_W-1:0] == FAMILY_CODE);
    end
  end

  assign family_code = shreg[FAMILY_W-1:0];
  assign serial_num  = shreg[FAMILY_W +: SERIAL_W];
  assign crc_byte    = shreg[ADDR_BITS-1 -: CRC_W];

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> bit_ready && !done && !crc_ok && !family_ok);
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !last) |=> $stable({crc_ok, family_ok}));
  p_residue_agree_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (crc_ok == (crc_residue == '0)));
  p_family_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (family_ok == (family_code == FAMILY_CODE)));
endmodule

// File: tb/rom_addr_crc_check_test.sv
module rom_addr_crc_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        bit_ready, done, crc_ok, family_ok;
  logic [7:0]  family_code;
  logic [47:0] serial_num;
  logic [7:0]  crc_byte;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rom_addr_crc_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .done(done),
    .crc_ok(crc_ok), .family_ok(family_ok), .family_code(family_code),
    .serial_num(serial_num), .crc_byte(crc_byte)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [63:0] a, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = a[i] ^ c[0];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_addr(input logic [7:0] fam, input logic [47:0] ser);
    logic [63:0] p = {8'h00, ser, fam};
    return {ref_crc(p, 56), ser, fam};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_frame(input logic [63:0] a, input int gap, input bit full);
    logic exp_crc = (ref_crc(a, 56) == a[63:56]);
    logic exp_fam = (a[7:0] == 8'h3D);
    pulse_start();
    if (full) begin
      chk("R2 ready after start", 64'(bit_ready), 64'd1);
      chk("R2 flags cleared", {61'd0, done, crc_ok, family_ok}, 64'd0);
    end
    for (int i = 0; i < 64; i++) begin
      if (gap != 0 && (i % gap) == 0) begin
        bit_valid = 1'b0;
        bit_data  = ~a[i];
        @(negedge clk);
      end
      bit_valid = 1'b1;
      bit_data  = a[i];
      @(negedge clk);
      if (full && i < 63) chk("R5 no early done", 64'(done), 64'd0);
    end
    bit_valid = 1'b0;
    chk("R5 done after last bit", 64'(done), 64'd1);
    chk("R4 ready low after frame", 64'(bit_ready), 64'd0);
    chk("R6 crc_ok", 64'(crc_ok), 64'(exp_crc));
    chk("R7 family_ok", 64'(family_ok), 64'(exp_fam));
    chk("R8 family field", 64'(family_code), 64'(a[7:0]));
    chk("R8 serial field", 64'(serial_num), 64'(a[55:8]));
    chk("R9 crc field", 64'(crc_byte), 64'(a[63:56]));
    @(negedge clk);
    chk("R5 done one cycle", 64'(done), 64'd0);
    if (full) begin
      for (int k = 0; k < 4; k++) begin
        bit_valid = 1'b1;
        bit_data  = k[0] ^ a[k];
        @(negedge clk);
        chk("R4 ready stays low", 64'(bit_ready), 64'd0);
      end
      bit_valid = 1'b0;
      chk("R4 fields unchanged", {crc_byte, serial_num, family_code}, a);
      chk("R8 flags held", {62'd0, crc_ok, family_ok}, {62'd0, exp_crc, exp_fam});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] base;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'd0, bit_ready, done, crc_ok, family_ok}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {60'd0, bit_ready, done, crc_ok, family_ok}, 64'd0);
    bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R3 no accept while idle", 64'(serial_num), 64'd0);

    // R7 R6: every family code with a correct CRC
    for (int f = 0; f < 256; f++) begin
      logic [47:0] ser = {6{f[7:0]}} ^ 48'hA5C3_1F20_7E94;
      run_frame(make_addr(f[7:0], ser), (f % 4) + 2, (f % 16) == 0);
    end

    // R6 R9: every single-bit corruption of a valid address
    base = make_addr(8'h3D, 48'h0123_4567_89AB);
    run_frame(base, 0, 1'b1);
    for (int b = 0; b < 64; b++) begin
      logic [63:0] bad = base ^ (64'd1 << b);
      run_frame(bad, 3, 1'b1);
    end

    // R10: abort a partial frame with start, then a full clean frame
    pulse_start();
    for (int i = 0; i < 20; i++) begin
      bit_valid = 1'b1;
      bit_data  = i[0];
      @(negedge clk);
    end
    bit_valid = 1'b0;
    run_frame(make_addr(8'h3D, 48'hFEDC_BA98_7654), 0, 1'b1);
    chk("R10 restart yields valid frame", 64'(crc_ok), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule